// File: doc/BRIEF.md
# Scatter-gather to descriptor table converter

This block turns a list of scatter-gather memory segments into the descriptor entries that a bus-master disk DMA engine walks. Each segment arrives as a 32-bit start address and a 32-bit byte length, with a flag on the final segment of a table. Each descriptor goes out as a pair of 32-bit words: a base address and a control word that carries the byte count. A table's entries stream to a writer, and the table ends with a one-cycle completion pulse that reports success and the number of entries written. On a failure the caller drops the table and moves the transfer by programmed I/O.

A segment is cut into chunks so that no descriptor runs across a 64 KiB address boundary. Two count formats are supported. In the standard format the count sits in the low half of the control word, a whole 64 KiB chunk is written as two 32 KiB halves (some controllers read a count field of zero as zero bytes), and the final entry carries an end marker. In the alternate format the upper half holds the number of 32-bit words minus one, and no end marker is written.

Both streams use valid/ready. The segment source must hold `seg_valid` and its data steady until `seg_ready` is seen high at a clock edge. `ent_valid` stays high with steady address and control until the writer raises `ent_ready`. The writer may stall for any number of cycles, and that back-pressure reaches the segment input. Each entry is held back by one slot until its successor or the end of the table is known, so that the end marker can be set before the entry is shown.

Top module: `prd_builder`

## Requirements
- R1: A segment transfers on a clock edge with `seg_valid` and `seg_ready` both high, and an entry transfers on an edge with `ent_valid` and `ent_ready` both high. Once `ent_valid` is raised, it and `ent_addr`/`ent_ctrl` stay unchanged until the entry is taken.
- R2: The entries of a segment cover it in address order. Each chunk is the smaller of the bytes left in the segment and the distance to the next 64 KiB boundary, so no entry crosses such a boundary.
- R3: In standard mode the control word holds the chunk length in bits 15:0, and bits 30:16 are zero.
- R4: In standard mode a chunk of exactly 65536 bytes gives two entries: one at the chunk address and one at that address plus 0x8000, each with a count of 0x8000.
- R5: In standard mode bit 31 of the control word is set on the last entry of a successful table and is clear on every other entry.
- R6: In alternate mode control bits 31:16 hold (chunk length / 4) − 1 and bits 15:0 are zero. A 64 KiB chunk is one entry with 0x3FFF in bits 31:16. No end marker is set.
- R7: The table holds at most MAX_ENTRIES entries. If one more entry is needed, including the second half of a split, the table fails. The entry that was still held back is discarded. The remaining segments are taken and dropped through the one flagged last.
- R8: A segment of length zero produces no entry. A table that produces no entry at all fails.
- R9: A segment of nonzero length whose address or length is odd (standard mode), or not a multiple of 4 (alternate mode), fails the table, with the same discard and drain as R7.
- R10: `done` is high for exactly one cycle after the table's last entry has been taken. `done_ok` is 1 on success, and `done_count` then gives the number of entries. On failure `done_ok` is 0 and `done_count` is 0.
- R11: `mode_alt` is sampled when the first segment of a table is accepted (0 = standard, 1 = alternate). Changes to it later in the same table have no effect.
- R12: After reset `seg_ready` is 1, and `ent_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_alt | input | 1 | Count format for the next table: 0 standard, 1 alternate |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be taken |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Final segment of the table |
| ent_valid | output | 1 | Descriptor entry offered |
| ent_ready | input | 1 | Writer takes the entry |
| ent_addr | output | 32 | Entry base address |
| ent_ctrl | output | 32 | Entry control/count word |
| done | output | 1 | One-cycle table completion pulse |
| done_ok | output | 1 | Table built successfully (valid with done) |
| done_count | output | CNT_W | Entry count on success, else 0 (valid with done) |

## Verification
The checker assumes that a segment's address plus its length does not pass 2^32, and that the source holds each offered segment steady until it is taken. Under those assumptions, every entry the design emits has the boundary and format properties on its own, whatever the writer does. The stimulus keeps all addresses under 16 MiB. It holds a segment until `seg_ready` has been seen and only then moves on. It makes misaligned segments only on purpose, to exercise R9, and it drops `ent_ready` at random so that every stall pattern is covered.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int WORD_W  = 32;
  localparam int SPAN_W  = 16;
  localparam int CHUNK_W = SPAN_W + 1;

  localparam logic [CHUNK_W-1:0] FULL_SPAN = CHUNK_W'(1) << SPAN_W;
  localparam logic [CHUNK_W-1:0] HALF_SPAN = CHUNK_W'(1) << (SPAN_W - 1);

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] ctrl;
  } prd_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GEN,
    ST_FIN,
    ST_DRAIN,
    ST_END
  } ctl_state_t;

  // Control word for a chunk of len bytes (len in 1..65536).
  function automatic logic [WORD_W-1:0] enc_ctrl(input logic alt,
                                                 input logic [CHUNK_W-1:0] len);
    logic [SPAN_W-1:0] words_m1;
    words_m1 = {1'b0, len[CHUNK_W-1:2]} - SPAN_W'(1);
    if (alt) enc_ctrl = {words_m1, {SPAN_W{1'b0}}};
    else     enc_ctrl = {{SPAN_W{1'b0}}, len[SPAN_W-1:0]};
  endfunction
endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
  import prd_pkg::*;
(
  input  logic [WORD_W-1:0]  cur_addr,
  input  logic [WORD_W-1:0]  rem,
  input  logic               half2,
  input  logic               alt,
  output prd_ent_t           ent,
  output logic [CHUNK_W-1:0] step,
  output logic               split_first
);
  logic [CHUNK_W-1:0] span;
  logic [CHUNK_W-1:0] chunk;
  logic               full;

  always_comb begin
    span  = FULL_SPAN - {1'b0, cur_addr[SPAN_W-1:0]};
    chunk = (rem < WORD_W'(span)) ? rem[CHUNK_W-1:0] : span;
    full  = !alt && (chunk == FULL_SPAN);

    if (half2) begin
      ent.addr    = cur_addr + WORD_W'(HALF_SPAN);
      ent.ctrl    = enc_ctrl(1'b0, HALF_SPAN);
      step        = FULL_SPAN;
      split_first = 1'b0;
    end else if (full) begin
      ent.addr    = cur_addr;
      ent.ctrl    = enc_ctrl(1'b0, HALF_SPAN);
      step        = '0;
      split_first = 1'b1;
    end else begin
      ent.addr    = cur_addr;
      ent.ctrl    = enc_ctrl(alt, chunk);
      step        = chunk;
      split_first = 1'b0;
    end
  end
endmodule

// File: rtl/prd_entry_pipe.sv
module prd_entry_pipe
  import prd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  prd_ent_t          push_ent,
  input  logic              finish,
  input  logic              mark,
  input  logic              drop,
  input  logic              ent_ready,
  output logic              pend_v,
  output logic              out_free,
  output logic              ent_valid,
  output logic [WORD_W-1:0] ent_addr,
  output logic [WORD_W-1:0] ent_ctrl
);
  prd_ent_t pend_q;
  prd_ent_t out_q;
  logic     out_v;
  logic     move;

  assign out_free  = !out_v || ent_ready;
  assign move      = (push || finish) && pend_v;
  assign ent_valid = out_v;
  assign ent_addr  = out_q.addr;
  assign ent_ctrl  = out_q.ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      out_v  <= 1'b0;
      pend_q <= '0;
      out_q  <= '0;
    end else begin
      if (out_v && ent_ready) out_v <= 1'b0;
      if (move) begin
        out_v      <= 1'b1;
        out_q.addr <= pend_q.addr;
        out_q.ctrl <= {pend_q.ctrl[WORD_W-1] | (finish & mark),
                       pend_q.ctrl[WORD_W-2:0]};
      end
      if (push) begin
        pend_q <= push_ent;
        pend_v <= 1'b1;
      end else if (finish || drop) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prd_seg_ctl.sv
module prd_seg_ctl
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_alt,
  input  logic               seg_valid,
  output logic               seg_ready,
  input  logic [WORD_W-1:0]  seg_addr,
  input  logic [WORD_W-1:0]  seg_len,
  input  logic               seg_last,
  input  logic [CHUNK_W-1:0] step,
  input  logic               split_first,
  input  logic               pend_v,
  input  logic               out_free,
  input  logic               out_v,
  output logic [WORD_W-1:0]  addr_q,
  output logic [WORD_W-1:0]  rem_q,
  output logic               half2_q,
  output logic               alt_q,
  output logic               push,
  output logic               finish,
  output logic               mark,
  output logic               drop,
  output logic               done,
  output logic               done_ok,
  output logic [CNT_W-1:0]   done_count
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ENTRIES);

  ctl_state_t       state;
  logic             last_q, fresh_q, ok_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, eff_alt, misal, busy, ovf, fail_now;

  always_comb begin
    seg_ready = (state == ST_IDLE) || (state == ST_DRAIN);
    accept    = seg_valid && seg_ready;
    eff_alt   = fresh_q ? mode_alt : alt_q;
    misal     = (seg_len != '0) &&
                (eff_alt ? ((|seg_addr[1:0]) || (|seg_len[1:0]))
                         : (seg_addr[0] || seg_len[0]));
    busy      = (rem_q != '0);
    ovf       = (state == ST_GEN) && busy && (cnt_q == MAX_C);
    push      = (state == ST_GEN) && busy && !ovf && (!pend_v || out_free);
    finish    = (state == ST_FIN) && pend_v && out_free;
    mark      = !alt_q;
    fail_now  = ((state == ST_IDLE) && accept && misal) || ovf;
    drop      = fail_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      half2_q    <= 1'b0;
      alt_q      <= 1'b0;
      last_q     <= 1'b0;
      fresh_q    <= 1'b1;
      ok_q       <= 1'b1;
      cnt_q      <= '0;
      done       <= 1'b0;
      done_ok    <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          fresh_q <= 1'b0;
          if (fresh_q) alt_q <= mode_alt;
          addr_q  <= seg_addr;
          rem_q   <= seg_len;
          last_q  <= seg_last;
          half2_q <= 1'b0;
          if (misal) begin
            ok_q  <= 1'b0;
            state <= seg_last ? ST_END : ST_DRAIN;
          end else begin
            state <= ST_GEN;
          end
        end
        ST_GEN: begin
          if (!busy) begin
            state <= last_q ? ST_FIN : ST_IDLE;
          end else if (ovf) begin
            ok_q  <= 1'b0;
            state <= last_q ? ST_END : ST_DRAIN;
          end else if (push) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (split_first) begin
              half2_q <= 1'b1;
            end else begin
              half2_q <= 1'b0;
              addr_q  <= addr_q + WORD_W'(step);
              rem_q   <= rem_q - WORD_W'(step);
            end
          end
        end
        ST_FIN: begin
          if (!pend_v) begin
            ok_q  <= 1'b0;
            state <= ST_END;
          end else if (out_free) begin
            state <= ST_END;
          end
        end
        ST_DRAIN: if (accept && seg_last) state <= ST_END;
        ST_END: if (!out_v) begin
          done       <= 1'b1;
          done_ok    <= ok_q;
          done_count <= ok_q ? cnt_q : '0;
          cnt_q      <= '0;
          ok_q       <= 1'b1;
          fresh_q    <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_builder.sv
module prd_builder
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_alt,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [WORD_W-1:0] seg_addr,
  input  logic [WORD_W-1:0] seg_len,
  input  logic              seg_last,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic [WORD_W-1:0] ent_addr,
  output logic [WORD_W-1:0] ent_ctrl,
  output logic              done,
  output logic              done_ok,
  output logic [CNT_W-1:0]  done_count
);
  logic [WORD_W-1:0]  addr_q, rem_q;
  logic               half2_q, tbl_alt;
  prd_ent_t           gen_ent;
  logic [CHUNK_W-1:0] step;
  logic               split_first;
  logic               push, finish, mark, drop, pend_v, out_free;

  prd_chunk_calc u_calc (
    .cur_addr    (addr_q),
    .rem         (rem_q),
    .half2       (half2_q),
    .alt         (tbl_alt),
    .ent         (gen_ent),
    .step        (step),
    .split_first (split_first)
  );

  prd_seg_ctl #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_alt    (mode_alt),
    .seg_valid   (seg_valid),
    .seg_ready   (seg_ready),
    .seg_addr    (seg_addr),
    .seg_len     (seg_len),
    .seg_last    (seg_last),
    .step        (step),
    .split_first (split_first),
    .pend_v      (pend_v),
    .out_free    (out_free),
    .out_v       (ent_valid),
    .addr_q      (addr_q),
    .rem_q       (rem_q),
    .half2_q     (half2_q),
    .alt_q       (tbl_alt),
    .push        (push),
    .finish      (finish),
    .mark        (mark),
    .drop        (drop),
    .done        (done),
    .done_ok     (done_ok),
    .done_count  (done_count)
  );

  prd_entry_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_ent  (gen_ent),
    .finish    (finish),
    .mark      (mark),
    .drop      (drop),
    .ent_ready (ent_ready),
    .pend_v    (pend_v),
    .out_free  (out_free),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_ctrl  (ent_ctrl)
  );
endmodule

// File: rtl/prd_builder_chk.sv
module prd_builder_chk #(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_ready,
  input logic             ent_valid,
  input logic             ent_ready,
  input logic [31:0]      ent_addr,
  input logic [31:0]      ent_ctrl,
  input logic             done,
  input logic             done_ok,
  input logic [CNT_W-1:0] done_count,
  input logic             tbl_alt
);
  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_addr) && $stable(ent_ctrl));

  assert_no_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !tbl_alt |->
      ({1'b0, ent_addr[15:0]} + {1'b0, ent_ctrl[15:0]}) <= 17'h10000);

  assert_std_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !tbl_alt |-> ent_ctrl[30:16] == '0 && ent_ctrl[15:0] != '0);

  assert_alt_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && tbl_alt |-> !ent_ctrl[31] && ent_ctrl[15:0] == '0);

  assert_std_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !tbl_alt |-> !ent_addr[0] && !ent_ctrl[0]);

  assert_alt_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && tbl_alt |-> ent_addr[1:0] == 2'b00);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ent_valid && seg_ready);

  assert_ok_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_ok |-> done_count != '0 && done_count <= CNT_W'(MAX_ENTRIES));

  assert_fail_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok |-> done_count == '0);
endmodule

bind prd_builder prd_builder_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seg_ready  (seg_ready),
  .ent_valid  (ent_valid),
  .ent_ready  (ent_ready),
  .ent_addr   (ent_addr),
  .ent_ctrl   (ent_ctrl),
  .done       (done),
  .done_ok    (done_ok),
  .done_count (done_count),
  .tbl_alt    (tbl_alt)
);

// File: tb/test_prd_builder.sv
module test_prd_builder;
  localparam int MAXE = 12;
  localparam int CW   = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_alt = 1'b0;
  logic seg_valid = 1'b0, seg_last = 1'b0;
  logic [31:0] seg_addr = '0, seg_len = '0;
  logic seg_ready, ent_valid, done, done_ok;
  logic ent_ready = 1'b0;
  logic [31:0] ent_addr, ent_ctrl;
  logic [CW-1:0] done_count;

  always #10 clk = ~clk;

  prd_builder #(.MAX_ENTRIES(MAXE)) i_prd_builder (
    .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr),
    .ent_ctrl(ent_ctrl), .done(done), .done_ok(done_ok), .done_count(done_count)
  );

  int total = 0, bad = 0, stall_err = 0;
  logic [31:0] s_addr [16];
  logic [31:0] s_len  [16];
  logic        s_mode [16];
  int          s_n;
  logic [31:0] e_addr [64];
  logic [31:0] e_ctrl [64];
  int          e_n, e_cnt;
  bit          e_ok;
  logic [31:0] g_addr [64];
  logic [31:0] g_ctrl [64];
  int          g_n, g_cnt;
  bit          g_ok;

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add_exp(input logic [31:0] a, input logic [31:0] c, inout int n);
    e_addr[n] = a;
    e_ctrl[n] = c;
    n++;
  endtask

  // Expected table from the requirements.
  task automatic model();
    bit alt = s_mode[0];
    bit ok = 1;
    int n = 0;
    for (int i = 0; i < s_n && ok; i++) begin
      logic [31:0] a = s_addr[i];
      logic [31:0] r = s_len[i];
      if (r != 0 && (alt ? (a[1:0] != 0 || r[1:0] != 0) : (a[0] || r[0]))) ok = 0;
      while (ok && r != 0) begin
        logic [31:0] span = 32'h10000 - {16'h0, a[15:0]};
        logic [31:0] c = (r < span) ? r : span;
        if (!alt && c == 32'h10000) begin
          if (n == MAXE) ok = 0;
          else begin
            add_exp(a, 32'h8000, n);
            if (n == MAXE) ok = 0;
            else add_exp(a + 32'h8000, 32'h8000, n);
          end
        end else if (n == MAXE) ok = 0;
        else add_exp(a, alt ? (((c >> 2) - 1) << 16) : c, n);
        a = a + c;
        r = r - c;
      end
    end
    if (ok && n == 0) ok = 0;
    if (ok) begin
      if (!alt) e_ctrl[n-1] = e_ctrl[n-1] | 32'h8000_0000;
      e_n = n;
      e_cnt = n;
    end else begin
      e_n = (n > 0) ? n - 1 : 0;
      e_cnt = 0;
    end
    e_ok = ok;
  endtask

  task automatic drive_segs();
    @(negedge clk);
    for (int i = 0; i < s_n; i++) begin
      bit acc;
      seg_valid = 1'b1;
      seg_addr  = s_addr[i];
      seg_len   = s_len[i];
      seg_last  = (i == s_n - 1);
      mode_alt  = s_mode[i];
      do begin
        acc = seg_ready;
        @(negedge clk);
      end while (!acc);
    end
    seg_valid = 1'b0;
    seg_last  = 1'b0;
  endtask

  task automatic collect(input bit stall);
    bit pv = 0, pr = 0;
    logic [31:0] pa = '0, pc = '0;
    g_n = 0;
    forever begin
      @(negedge clk);
      if (pv && !pr && !(ent_valid && ent_addr == pa && ent_ctrl == pc)) stall_err++;
      ent_ready = stall ? (($urandom % 4) != 0) : 1'b1;
      pv = ent_valid; pr = ent_ready; pa = ent_addr; pc = ent_ctrl;
      if (ent_valid && ent_ready) begin
        if (g_n < 64) begin
          g_addr[g_n] = ent_addr;
          g_ctrl[g_n] = ent_ctrl;
        end
        g_n++;
      end
      if (done) begin
        g_ok = done_ok;
        g_cnt = int'(done_count);
        break;
      end
    end
  endtask

  task automatic run_table(input string tag, input bit stall);
    model();
    fork
      drive_segs();
      collect(stall);
    join
    check(g_n == e_n, tag, "entry count (R2)", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      check(g_addr[i] == e_addr[i], tag, $sformatf("entry %0d addr", i), g_addr[i], e_addr[i]);
      check(g_ctrl[i] == e_ctrl[i], tag, $sformatf("entry %0d ctrl", i), g_ctrl[i], e_ctrl[i]);
    end
    check(g_ok == e_ok, tag, "done_ok (R10)", 32'(g_ok), 32'(e_ok));
    check(g_cnt == e_cnt, tag, "done_count (R10)", g_cnt, e_cnt);
  endtask

  task automatic set_seg(input int i, input logic [31:0] a, input logic [31:0] l,
                         input logic m);
    s_addr[i] = a;
    s_len[i]  = l;
    s_mode[i] = m;
  endtask

  task automatic rand_table();
    logic alt = 1'($urandom % 2);
    s_n = 1 + int'($urandom % 5);
    for (int i = 0; i < s_n; i++) begin
      logic [31:0] a = ($urandom % 32'h0100_0000);
      logic [31:0] l;
      int sel = int'($urandom % 8);
      case (sel)
        0: l = 0;
        1: l = 1 + ($urandom % 32'h400);
        2: l = 1 + ($urandom % 32'h18000);
        3: begin a = a & 32'hFFFF_0000; l = 32'h10000; end
        default: l = 1 + ($urandom % 32'h3000);
      endcase
      if (alt) begin a = a & ~32'h3; l = l & ~32'h3; end
      else begin a = a & ~32'h1; l = l & ~32'h1; end
      if (($urandom % 16) == 0) a = a | 32'h1;
      set_seg(i, a, l, (i == 0) ? alt : 1'($urandom % 2));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_ready == 1'b1, "R12", "seg_ready after reset", 32'(seg_ready), 1);
    check(ent_valid == 1'b0, "R12", "ent_valid after reset", 32'(ent_valid), 0);
    check(done == 1'b0, "R12", "done after reset", 32'(done), 0);

    // R3 R5: single small segment, standard mode
    s_n = 1; set_seg(0, 32'h1000, 32'h200, 0);
    run_table("R3_R5_single", 0);
    // R2: crossing a 64 KiB boundary
    s_n = 1; set_seg(0, 32'h1FFF0, 32'h40, 0);
    run_table("R2_cross", 1);
    // R4: aligned full 64 KiB chunk splits
    s_n = 1; set_seg(0, 32'h30000, 32'h10000, 0);
    run_table("R4_split", 1);
    // R6: same chunk in alternate mode is one entry
    s_n = 1; set_seg(0, 32'h30000, 32'h10000, 1);
    run_table("R6_alt_full", 1);
    s_n = 2; set_seg(0, 32'h4000, 32'h24, 1); set_seg(1, 32'hFFFC, 32'h8, 1);
    run_table("R6_alt_cross", 1);
    // R8: only zero-length segments
    s_n = 2; set_seg(0, 32'h100, 0, 0); set_seg(1, 32'h200, 0, 0);
    run_table("R8_empty", 1);
    // R8: zero-length in the middle adds nothing
    s_n = 3; set_seg(0, 32'h100, 32'h10, 0); set_seg(1, 32'h200, 0, 0);
    set_seg(2, 32'h300, 32'h20, 0);
    run_table("R8_zero_mid", 1);
    // R7: exactly MAXE entries succeeds, one more fails
    s_n = 1; set_seg(0, 32'h0, 32'hC0000, 1);
    run_table("R7_at_limit", 1);
    s_n = 2; set_seg(0, 32'h0, 32'hD0000, 1); set_seg(1, 32'h0, 32'h40, 1);
    run_table("R7_over", 1);
    // R7: overflow on the second half of a split
    s_n = 12;
    for (int i = 0; i < 11; i++) set_seg(i, 32'h100 * i, 32'h10, 0);
    set_seg(11, 32'h50000, 32'h10000, 0);
    run_table("R7_split_over", 1);
    // R9: misaligned segments
    s_n = 2; set_seg(0, 32'h1000, 32'h10, 0); set_seg(1, 32'h2001, 32'h10, 0);
    run_table("R9_std_odd", 1);
    s_n = 1; set_seg(0, 32'h2002, 32'h10, 1);
    run_table("R9_alt_misal", 1);
    // R11: mode change after first segment ignored
    s_n = 2; set_seg(0, 32'h2000, 32'h100, 0); set_seg(1, 32'h4002, 32'h12, 1);
    run_table("R11_mode_hold", 1);
    s_n = 2; set_seg(0, 32'h2000, 32'h100, 1); set_seg(1, 32'h4000, 32'h10, 0);
    run_table("R11_mode_hold_alt", 1);

    for (int t = 0; t < 60; t++) begin
      rand_table();
      run_table("R2_R5_R6_random", 1);
    end

    check(stall_err == 0, "R1", "stalled entry changed", stall_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule